// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target with Deferred Write Commit

This block is an I2C target that gives a bus controller access to a bank of five 8-bit registers. A fast system clock samples SCL and SDA through two-flop synchronizers. An edge stage on the sampled lines finds SCL rise and fall, START, repeated START and STOP. The target answers only to a device byte whose upper nibble is a fixed code and whose next three bits equal three strap inputs. After a write-mode device byte it takes one register address byte, which also loads the read pointer. Reads then stream bytes from the pointer while the controller keeps acknowledging.

A write never touches a register at once. The data byte is held in a staging register, and the commit starts only when a STOP follows the complete data byte and its acknowledge. The commit is a timed busy window of `COMMIT_CYCLES` system clocks. During the window every bus event is ignored and SDA stays released. The addressed register takes its new value when the window ends. Any other STOP position ends the transfer and leaves every register as it was.

Top module: `i2c_deferred_regs`

## Requirements
- R1: The target acknowledges a device byte only when bits 7..4 are 0101 and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects the direction: 1 is read, 0 is write. A device byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R2: The target pulls SDA low during the ninth clock after a matching device byte, after the address byte, and after the data byte of a write.
- R3: A write (START, device byte with bit 0 = 0, address, data, STOP) changes no register until the commit window ends. The addressed register then holds the data byte, about `COMMIT_CYCLES` clocks after the STOP.
- R4: A STOP that arrives inside a byte, or before a full data byte and its acknowledge, leaves every register unchanged and starts no commit window. The next transfer is answered at once.
- R5: While a commit window runs, all SCL and SDA activity is ignored. No acknowledge is driven, and nothing sent in the window affects any register.
- R6: A current-address read (START, device byte with bit 0 = 1) returns data beginning at the current pointer.
- R7: A random read (START, write-mode device byte, address, repeated START, read-mode device byte) returns data beginning at the address sent.
- R8: The target sends another byte after each controller acknowledge. After a controller NACK it releases SDA and sends nothing more until the next START.
- R9: The pointer advances by one with every byte sent. Pointer values 0..4 select registers 0..4, and any higher value reads as 0xFF.
- R10: A write addressed above 4 is acknowledged on all three bytes, but it changes no register.
- R11: After reset, all registers read 0x00 and SDA is released.
- R12: Every byte is transferred most significant bit first, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Strap levels matched against device byte bits 3..1 |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| regs_o | output | NUM_REGS*8 | Register contents, register k at bits 8k+7..8k |

## Verification
Every bus edge reaches the control logic about three system clocks after it appears on the pins: two synchronizer flops and one edge-detect flop. The SDA enable therefore changes three clocks after the SCL fall that causes it. The bench holds each SCL phase for six clocks and samples SDA in the middle of the high phase, so an acknowledge or data bit has settled before it is read. A committed value appears `COMMIT_CYCLES` plus about four clocks after the STOP. The bench checks the register once well inside the window, where the old value must still be present, and again well after the window has closed. The abort checks wait longer than a full window before they read the registers, so a commit started by mistake would be seen.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ID,
    S_ADDR,
    S_WDATA,
    S_WDONE,
    S_RDATA,
    S_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[LAST];
      sda_q <= sda_ff[LAST];
    end
  end

  assign scl_o      = scl_ff[LAST];
  assign sda_o      = sda_ff[LAST];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL is held high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regs_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b0101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] strap_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_ptr_o,
  output logic       sda_oe_o,
  output logic       commit_o,
  output logic [7:0] commit_addr_o,
  output logic [7:0] commit_data_o
);
  tgt_state_e state_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shift_q, tx_q, ptr_q, caddr_q, cdata_q;
  logic       oe_q, mack_q, rw_q, commit_q;
  logic       id_match;

  assign id_match = (shift_q[7:1] == {DEV_CODE, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      caddr_q   <= '0;
      cdata_q   <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
      rw_q      <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (busy_i) begin
        // deaf while the commit window runs
        state_q   <= S_IDLE;
        oe_q      <= 1'b0;
        bit_cnt_q <= '0;
      end else if (stop_i) begin
        commit_q  <= (state_q == S_WDONE);
        state_q   <= S_IDLE;
        oe_q      <= 1'b0;
        bit_cnt_q <= '0;
      end else if (start_i) begin
        state_q   <= S_ID;
        oe_q      <= 1'b0;
        bit_cnt_q <= '0;
      end else if (scl_rise_i) begin
        case (state_q)
          S_ID, S_ADDR, S_WDATA: begin
            if (bit_cnt_q < 4'd8) shift_q <= {shift_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          S_RDATA: begin
            if (bit_cnt_q == 4'd8) mack_q <= ~sda_i;
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          default: ;
        endcase
      end else if (scl_fall_i) begin
        if (state_q == S_WDONE) begin
          // clocking a second data byte: drop the staged write
          state_q <= S_IGNORE;
        end else if (bit_cnt_q == 4'd8) begin
          case (state_q)
            S_ID: begin
              rw_q <= shift_q[0];
              if (id_match) oe_q <= 1'b1;
              else begin
                state_q   <= S_IGNORE;
                bit_cnt_q <= '0;
              end
            end
            S_ADDR: begin
              oe_q  <= 1'b1;
              ptr_q <= shift_q;
            end
            S_WDATA: begin
              oe_q    <= 1'b1;
              caddr_q <= ptr_q;
              cdata_q <= shift_q;
            end
            S_RDATA: begin
              oe_q  <= 1'b0;
              ptr_q <= ptr_q + 8'd1;
            end
            default: ;
          endcase
        end else if (bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          oe_q      <= 1'b0;
          case (state_q)
            S_ID: begin
              if (rw_q) begin
                state_q <= S_RDATA;
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                state_q <= S_ADDR;
              end
            end
            S_ADDR:  state_q <= S_WDATA;
            S_WDATA: state_q <= S_WDONE;
            S_RDATA: begin
              if (mack_q) begin
                tx_q <= rd_data_i;
                oe_q <= ~rd_data_i[7];
              end else begin
                state_q <= S_IGNORE;
              end
            end
            default: ;
          endcase
        end else if (state_q == S_RDATA && bit_cnt_q != 4'd0) begin
          oe_q <= ~tx_q[6];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign rd_ptr_o      = ptr_q;
  assign sda_oe_o      = oe_q;
  assign commit_o      = commit_q;
  assign commit_addr_o = caddr_q;
  assign commit_data_o = cdata_q;

  p_oe_quiet_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !oe_q);

  p_release_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE || state_q == S_IGNORE) |-> !oe_q);

  p_oe_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);
endmodule

// File: rtl/i2c_commit_bank.sv
module i2c_commit_bank #(
  parameter int         NUM_REGS      = 5,
  parameter int         COMMIT_CYCLES = 1000,
  parameter logic [7:0] RESET_VAL     = 8'h00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic [7:0]            commit_addr_i,
  input  logic [7:0]            commit_data_i,
  input  logic [7:0]            rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic                  busy_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);

  logic          busy_q, done;
  logic [CW-1:0] cnt_q;
  logic [7:0]    pend_addr_q, pend_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (commit_i) begin
      busy_q      <= 1'b1;
      cnt_q       <= CW'(COMMIT_CYCLES - 1);
      pend_addr_q <= commit_addr_i;
      pend_data_q <= commit_data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done = busy_q && (cnt_q == '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             val_q <= RESET_VAL;
      else if (done && pend_addr_q == 8'(i))   val_q <= pend_data_q;
    end
    assign regs_o[i*8 +: 8] = val_q;
  end

  // out-of-range locations read as all ones
  always_comb begin
    rd_data_o = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_addr_i == 8'(k)) rd_data_o = regs_o[k*8 +: 8];
    end
  end

  assign busy_o = busy_q;

  p_no_commit_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_q);

  p_regs_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(regs_o));

  p_high_addr_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && pend_addr_q >= 8'(NUM_REGS)) |=> $stable(regs_o));
endmodule

// File: rtl/i2c_deferred_regs.sv
module i2c_deferred_regs #(
  parameter int         NUM_REGS      = 5,
  parameter int         COMMIT_CYCLES = 1000,
  parameter int         SYNC_STAGES   = 2,
  parameter logic [3:0] DEV_CODE      = 4'b0101,
  parameter logic [7:0] RESET_VAL     = 8'h00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [2:0]            strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       busy, commit;
  logic [7:0] commit_addr, commit_data, rd_ptr, rd_data;

  i2c_bus_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_target_fsm #(
    .DEV_CODE(DEV_CODE)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .busy_i        (busy),
    .scl_i         (scl_s),
    .sda_i         (sda_s),
    .scl_rise_i    (scl_rise),
    .scl_fall_i    (scl_fall),
    .start_i       (start_det),
    .stop_i        (stop_det),
    .strap_i       (strap_i),
    .rd_data_i     (rd_data),
    .rd_ptr_o      (rd_ptr),
    .sda_oe_o      (sda_oe_o),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  i2c_commit_bank #(
    .NUM_REGS      (NUM_REGS),
    .COMMIT_CYCLES (COMMIT_CYCLES),
    .RESET_VAL     (RESET_VAL)
  ) i_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .commit_addr_i (commit_addr),
    .commit_data_i (commit_data),
    .rd_addr_i     (rd_ptr),
    .rd_data_o     (rd_data),
    .busy_o        (busy),
    .regs_o        (regs_o)
  );
endmodule

// File: tb/test_i2c_deferred_regs.sv
`timescale 1ns/1ps
module test_i2c_deferred_regs;
  localparam int         NREG   = 5;
  localparam int         COMMIT = 600;
  localparam int         Q      = 6;
  localparam logic [2:0] STRAP  = 3'b101;
  localparam logic [7:0] ID_W   = {4'b0101, STRAP, 1'b0};
  localparam logic [7:0] ID_R   = {4'b0101, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_deferred_regs #(
    .NUM_REGS      (NREG),
    .COMMIT_CYCLES (COMMIT)
  ) i_i2c_deferred_regs (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .strap_i  (STRAP),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    ack = ~sda_bus; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      d[i] = sda_bus; wait_clk(Q);
      scl_m = 1'b0;
    end
    sda_m = ~mack; wait_clk(Q);
    scl_m = 1'b1;  wait_clk(2*Q);
    scl_m = 1'b0;  wait_clk(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    logic k;
    bus_start();
    write_byte(ID_W, k); acks[2] = k;
    write_byte(a, k);    acks[1] = k;
    write_byte(d, k);    acks[0] = k;
    bus_stop();
  endtask

  task automatic write_commit(input logic [7:0] a, input logic [7:0] d);
    logic [2:0] acks;
    do_write(a, d, acks);
    check("R2 write acks", acks, 3'b111);
    wait_clk(COMMIT + 40);
    if (a < NREG) check("R3/R12 committed value", reg_at(a), d);
  endtask

  task automatic t_reset();
    check("R11 sda released", sda_oe, 1'b0);
    for (int i = 0; i < NREG; i++) check("R11 reset reg", reg_at(i), 8'h00);
  endtask

  task automatic t_bad_id();
    logic k;
    bus_start(); write_byte({4'b0101, 3'b100, 1'b0}, k); bus_stop();
    check("R1 strap mismatch no ack", k, 1'b0);
    bus_start(); write_byte({4'b0110, STRAP, 1'b0}, k); bus_stop();
    check("R1 code mismatch no ack", k, 1'b0);
    bus_start(); write_byte(ID_R, k);
    check("R1 matching id ack", k, 1'b1);
    begin
      logic [7:0] d;
      read_byte(1'b0, d);
    end
    bus_stop();
    check("R8 released after nack", sda_oe, 1'b0);
  endtask

  task automatic t_write_deaf();
    logic [2:0] acks;
    logic k;
    do_write(8'h02, 8'h2D, acks);
    check("R2 write acks", acks, 3'b111);
    check("R3 not yet committed", reg_at(2), 8'h00);
    bus_start(); write_byte(ID_W, k); bus_stop();
    check("R5 no ack while busy", k, 1'b0);
    check("R3 still old inside window", reg_at(2), 8'h00);
    wait_clk(COMMIT);
    check("R3/R12 committed after window", reg_at(2), 8'h2D);
  endtask

  task automatic t_write_rest();
    write_commit(8'h00, 8'h1E);
    write_commit(8'h04, 8'hC4);
    write_commit(8'h03, 8'h6B);
    write_commit(8'h01, 8'h17);
  endtask

  task automatic t_abort_mid();
    logic k;
    bus_start(); write_byte(ID_W, k); write_byte(8'h01, k);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_stop();
    wait_clk(20);
    bus_start(); write_byte(ID_W, k); bus_stop();
    check("R4 answered right after mid-byte stop", k, 1'b1);
    wait_clk(COMMIT + 40);
    check("R4 reg1 unchanged", reg_at(1), 8'h17);
  endtask

  task automatic t_abort_nodata();
    logic k;
    bus_start(); write_byte(ID_W, k); write_byte(8'h03, k); bus_stop();
    wait_clk(20);
    bus_start(); write_byte(ID_W, k); bus_stop();
    check("R4 answered right after no-data stop", k, 1'b1);
    wait_clk(COMMIT + 40);
    check("R4 reg3 unchanged", reg_at(3), 8'h6B);
  endtask

  task automatic t_high_write();
    logic [NREG*8-1:0] snap;
    logic [2:0] acks;
    snap = regs;
    do_write(8'h06, 8'h77, acks);
    check("R10 high address acks", acks, 3'b111);
    wait_clk(COMMIT + 40);
    check("R10 bank unchanged", regs, snap);
  endtask

  task automatic t_random_read();
    logic k;
    logic [7:0] d;
    bus_start(); write_byte(ID_W, k); write_byte(8'h02, k);
    bus_start(); write_byte(ID_R, k);
    check("R7 read id ack", k, 1'b1);
    read_byte(1'b0, d); bus_stop();
    check("R7/R12 random read reg2", d, 8'h2D);
  endtask

  task automatic t_seq_read();
    logic k;
    logic [7:0] d;
    bus_start(); write_byte(ID_W, k); write_byte(8'h03, k);
    bus_start(); write_byte(ID_R, k);
    read_byte(1'b1, d); check("R8 seq byte 0", d, 8'h6B);
    read_byte(1'b1, d); check("R9 seq byte 1", d, 8'hC4);
    read_byte(1'b0, d); check("R9 past top reads FF", d, 8'hFF);
    check("R8 released after final nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic k;
    logic [7:0] d;
    bus_start(); write_byte(ID_W, k); write_byte(8'h00, k);
    bus_start(); write_byte(ID_R, k); read_byte(1'b0, d); bus_stop();
    check("R7 read reg0", d, 8'h1E);
    bus_start(); write_byte(ID_R, k); read_byte(1'b0, d); bus_stop();
    check("R6 current read reg1", d, 8'h17);
    bus_start(); write_byte(ID_R, k); read_byte(1'b0, d); bus_stop();
    check("R9 pointer advanced to reg2", d, 8'h2D);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_bad_id();
    t_write_deaf();
    t_write_rest();
    t_abort_mid();
    t_abort_nodata();
    t_high_write();
    t_random_read();
    t_seq_read();
    t_current_read();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule